// File: doc/BRIEF.md
# Keyed Configuration Port with Watchdog Register Bank

This block is a byte-wide configuration port that occupies two neighbouring host addresses. The lower address is the index port and the address one above it is the data port. After reset the port is closed. A closed port answers every read with 0xFF, drops every data write, and watches index writes only for the opening key. Writing 0x87 to the index port twice in a row opens it. Writing 0xAA to the index port closes it again. The registers keep their contents while the port is closed.

While the port is open, an index write chooses a configuration register and data-port accesses read or write that register. The register space holds a logical-device number register, read-only identification registers, a small block of general read/write registers, and one bank of device registers. The bank is reached only while the logical-device number equals the watchdog device number. The bank holds an enable bit and sixteen general bytes. The enable bit and the bank contents go out as ports so that a watchdog core next to this block can use them.

The host side is a plain strobe interface, with one write strobe and one read strobe. Read data is registered.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is closed (`cfg_open`=0), the index and the logical-device number are 0x00, every bank register and `wdt_dev_en` are 0, and `bus_rdata` is 0x00.
- R2: While closed, a read of either port returns 0xFF and a data-port write changes no register.
- R3: Two index-port writes of 0x87 with no other index write between them open the port. `cfg_open` rises at the clock edge that takes the second key. A single key leaves it closed. Data-port accesses between the keys do not affect the sequence.
- R4: An index write of any value other than 0x87 after a single key restarts the sequence, so two fresh keys are then needed.
- R5: An index write of 0xAA while open closes the port at that edge. 0xAA is not taken as an index. The index and all register contents survive a close followed by a reopen.
- R6: While open, any other index write loads the index, an index-port read returns the index, and data-port accesses target the indexed register.
- R7: Registers 0x20/0x21 return the device ID, high byte at 0x20. Registers 0x23/0x24 return the manufacturer ID, high byte at 0x23. Register 0x22 returns the revision. Writes to these five registers are ignored.
- R8: Register 0x07 (logical-device number) and registers 0x25 to 0x2F are read/write bytes.
- R9: Register 0x30 and registers 0xF0 to 0xFF form the bank. The bank is reachable only when register 0x07 holds 0x07; otherwise bank reads return 0xFF and bank writes are ignored. Bit 0 of 0x30 is the device enable `wdt_dev_en`, and 0x30 reads back as {7'b0, enable}. Register 0xF0+k appears on `wdt_bank_regs[8k+7:8k]`.
- R10: A data-port read of an unimplemented register returns 0xFF, and a write to it changes nothing. Accesses to addresses other than the two ports are ignored and leave `bus_rdata` unchanged.
- R11: `bus_rdata` takes the read result at the clock edge that samples `bus_rd` on a port address and holds it until the next such read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cfg_open | output | 1 | Port is in configuration mode |
| wdt_dev_en | output | 1 | Watchdog device enable (bank register 0x30 bit 0) |
| wdt_bank_regs | output | 8*NUM_BANK | Bank registers 0xF0 upward, lowest register in the low byte |

## Verification
Every result is due exactly one clock edge after its stimulus. A write strobe changes the lock state, the index, a register, `cfg_open` or `wdt_dev_en` at the edge that samples it. A read strobe loads `bus_rdata` at the edge that samples it. The bench drives each strobe from one falling edge to the next and samples at that second falling edge, so exactly one rising edge falls between stimulus and observation. Each check that something is ignored reads the affected register back through the data port, or watches the enable and bank outputs, before any later write could change it.

// File: rtl/kcp_pkg.sv
package kcp_pkg;

  // Index-port keys
  localparam logic [7:0] KEY_OPEN  = 8'h87;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;

  // Global register addresses
  localparam logic [7:0] REG_LDN     = 8'h07;
  localparam logic [7:0] REG_DEV_HI  = 8'h20;
  localparam logic [7:0] REG_DEV_LO  = 8'h21;
  localparam logic [7:0] REG_REV     = 8'h22;
  localparam logic [7:0] REG_MFG_HI  = 8'h23;
  localparam logic [7:0] REG_MFG_LO  = 8'h24;

  // Banked enable register
  localparam logic [7:0] REG_ENA     = 8'h30;

  // Value returned for anything that cannot be read
  localparam logic [7:0] RD_EMPTY    = 8'hFF;

  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_st_e;

endpackage

// File: rtl/kcp_lock_fsm.sv
module kcp_lock_fsm
  import kcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open_o
);

  lock_st_e st_q, st_nxt;
  logic     st_en;

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      LK_CLOSED: if (wdata == KEY_OPEN) st_nxt = LK_HALF;
      LK_HALF:   st_nxt = (wdata == KEY_OPEN) ? LK_OPEN : LK_CLOSED;
      LK_OPEN:   if (wdata == KEY_CLOSE) st_nxt = LK_CLOSED;
      default:   st_nxt = LK_CLOSED;
    endcase
  end

  // Only index-port writes advance the machine
  assign st_en = idx_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= LK_CLOSED;
    else if (st_en) st_q <= st_nxt;
  end

  assign open_o = (st_q == LK_OPEN);

endmodule

// File: rtl/kcp_global_regs.sv
module kcp_global_regs
  import kcp_pkg::*;
#(
  parameter logic [15:0] DEV_ID  = 16'hA51C,
  parameter logic [7:0]  DEV_REV = 8'h03,
  parameter logic [15:0] MFG_ID  = 16'h5AC3,
  parameter int          GLB_LO  = 'h25,
  parameter int          GLB_N   = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] ldn_o,
  output logic       rd_hit,
  output logic [7:0] rd_val
);

  logic [7:0] ldn_q;
  logic       ldn_en;

  assign ldn_en = wr_en && (idx == REG_LDN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ldn_q <= '0;
    else if (ldn_en) ldn_q <= wdata;
  end

  assign ldn_o = ldn_q;

  // General read/write bytes
  logic [GLB_N-1:0]      g_sel;
  logic [GLB_N-1:0][7:0] g_term;

  for (genvar k = 0; k < GLB_N; k++) begin : g_glb
    localparam logic [7:0] ADDR = 8'(GLB_LO + k);
    logic [7:0] q;
    logic       en;
    assign g_sel[k] = (idx == ADDR);
    assign en       = wr_en && g_sel[k];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign g_term[k] = g_sel[k] ? q : '0;
  end

  logic [7:0] g_or;
  always_comb begin
    g_or = '0;
    for (int k = 0; k < GLB_N; k++) g_or = g_or | g_term[k];
  end

  // Read selection, identification registers are constants
  always_comb begin
    rd_hit = 1'b1;
    rd_val = RD_EMPTY;
    unique case (idx)
      REG_LDN:    rd_val = ldn_q;
      REG_DEV_HI: rd_val = DEV_ID[15:8];
      REG_DEV_LO: rd_val = DEV_ID[7:0];
      REG_REV:    rd_val = DEV_REV;
      REG_MFG_HI: rd_val = MFG_ID[15:8];
      REG_MFG_LO: rd_val = MFG_ID[7:0];
      default: begin
        rd_hit = |g_sel;
        rd_val = g_or;
      end
    endcase
  end

endmodule

// File: rtl/kcp_bank_regs.sv
module kcp_bank_regs
  import kcp_pkg::*;
#(
  parameter int BANK_LO  = 'hF0,
  parameter int NUM_BANK = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bank_sel,
  input  logic                  wr_en,
  input  logic [7:0]            idx,
  input  logic [7:0]            wdata,
  output logic                  ena_o,
  output logic [8*NUM_BANK-1:0] regs_o,
  output logic                  rd_hit,
  output logic [7:0]            rd_val
);

  logic bank_wr;
  assign bank_wr = wr_en && bank_sel;

  // Device enable bit
  logic ena_q, ena_en, ena_sel;
  assign ena_sel = (idx == REG_ENA);
  assign ena_en  = bank_wr && ena_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ena_q <= 1'b0;
    else if (ena_en) ena_q <= wdata[0];
  end

  assign ena_o = ena_q;

  // Bank bytes
  logic [NUM_BANK-1:0]      b_sel;
  logic [NUM_BANK-1:0][7:0] b_term;

  for (genvar k = 0; k < NUM_BANK; k++) begin : g_bank
    localparam logic [7:0] ADDR = 8'(BANK_LO + k);
    logic [7:0] q;
    logic       en;
    assign b_sel[k] = (idx == ADDR);
    assign en       = bank_wr && b_sel[k];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign regs_o[8*k +: 8] = q;
    assign b_term[k]        = b_sel[k] ? q : '0;
  end

  logic [7:0] b_or;
  always_comb begin
    b_or = '0;
    for (int k = 0; k < NUM_BANK; k++) b_or = b_or | b_term[k];
  end

  always_comb begin
    rd_hit = bank_sel && (ena_sel || (|b_sel));
    rd_val = ena_sel ? {7'b0, ena_q} : b_or;
  end

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import kcp_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h004E,
  parameter logic [15:0]       DEV_ID    = 16'hA51C,
  parameter logic [7:0]        DEV_REV   = 8'h03,
  parameter logic [15:0]       MFG_ID    = 16'h5AC3,
  parameter int                GLB_LO    = 'h25,
  parameter int                GLB_N     = 11,
  parameter logic [7:0]        WDT_LDN   = 8'h07,
  parameter int                BANK_LO   = 'hF0,
  parameter int                NUM_BANK  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  output logic                  cfg_open,
  output logic                  wdt_dev_en,
  output logic [8*NUM_BANK-1:0] wdt_bank_regs
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

  // Address decode
  logic at_idx, at_dat, idx_wr, dat_wr, rd_en;
  assign at_idx = (bus_addr == BASE_ADDR);
  assign at_dat = (bus_addr == DATA_ADDR);
  assign idx_wr = bus_wr && at_idx;
  assign dat_wr = bus_wr && at_dat && cfg_open;
  assign rd_en  = bus_rd && !bus_wr && (at_idx || at_dat);

  // Lock state
  kcp_lock_fsm u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_wr (idx_wr),
    .wdata  (bus_wdata),
    .open_o (cfg_open)
  );

  // Index latch: loads only while open, never with the close key
  logic [7:0] idx_q;
  logic       idx_en;
  assign idx_en = idx_wr && cfg_open && (bus_wdata != KEY_CLOSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= bus_wdata;
  end

  // Register files
  logic [7:0] ldn;
  logic       g_hit, b_hit;
  logic [7:0] g_val, b_val;

  kcp_global_regs #(
    .DEV_ID  (DEV_ID),
    .DEV_REV (DEV_REV),
    .MFG_ID  (MFG_ID),
    .GLB_LO  (GLB_LO),
    .GLB_N   (GLB_N)
  ) u_glb (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (dat_wr),
    .idx    (idx_q),
    .wdata  (bus_wdata),
    .ldn_o  (ldn),
    .rd_hit (g_hit),
    .rd_val (g_val)
  );

  kcp_bank_regs #(
    .BANK_LO  (BANK_LO),
    .NUM_BANK (NUM_BANK)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .bank_sel (ldn == WDT_LDN),
    .wr_en    (dat_wr),
    .idx      (idx_q),
    .wdata    (bus_wdata),
    .ena_o    (wdt_dev_en),
    .regs_o   (wdt_bank_regs),
    .rd_hit   (b_hit),
    .rd_val   (b_val)
  );

  // Read path
  logic [7:0] rd_nxt;
  always_comb begin
    rd_nxt = RD_EMPTY;
    if (cfg_open) begin
      if (at_idx)     rd_nxt = idx_q;
      else if (g_hit) rd_nxt = g_val;
      else if (b_hit) rd_nxt = b_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_nxt;
  end

endmodule

// File: rtl/keyed_cfg_port_chk.sv
module keyed_cfg_port_chk
  import kcp_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h004E,
  parameter int                NUM_BANK  = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [7:0]            bus_wdata,
  input logic [7:0]            bus_rdata,
  input logic                  cfg_open,
  input logic                  wdt_dev_en,
  input logic [8*NUM_BANK-1:0] wdt_bank_regs
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

  logic c_idx_wr, c_hit, c_rd;
  assign c_idx_wr = bus_wr && (bus_addr == BASE_ADDR);
  assign c_hit    = (bus_addr == BASE_ADDR) || (bus_addr == DATA_ADDR);
  assign c_rd     = bus_rd && !bus_wr && c_hit;

  a_r2_closed_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && !cfg_open) |=> (bus_rdata == RD_EMPTY));

  a_r2_closed_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(wdt_dev_en) && $stable(wdt_bank_regs)));

  a_r3_open_on_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(c_idx_wr && (bus_wdata == KEY_OPEN)));

  a_r3_open_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && !(c_idx_wr && (bus_wdata == KEY_CLOSE))) |=> cfg_open);

  a_r5_close_key: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && c_idx_wr && (bus_wdata == KEY_CLOSE)) |=> !cfg_open);

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !c_rd |=> $stable(bus_rdata));

endmodule

bind keyed_cfg_port keyed_cfg_port_chk #(
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR),
  .NUM_BANK  (NUM_BANK)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .bus_rd        (bus_rd),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .cfg_open      (cfg_open),
  .wdt_dev_en    (wdt_dev_en),
  .wdt_bank_regs (wdt_bank_regs)
);

// File: tb/sim_keyed_cfg_port.sv
`timescale 1ns/1ps
module sim_keyed_cfg_port;

  localparam logic [15:0] IDX = 16'h004E;
  localparam logic [15:0] DAT = 16'h004F;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [7:0]   bus_wdata = '0;
  logic [7:0]   bus_rdata;
  logic         cfg_open;
  logic         wdt_dev_en;
  logic [127:0] wdt_bank_regs;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  keyed_cfg_port u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .cfg_open      (cfg_open),
    .wdt_dev_en    (wdt_dev_en),
    .wdt_bank_regs (wdt_bank_regs)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic reg_wr(input logic [7:0] r, input logic [7:0] d);
    bwrite(IDX, r);
    bwrite(DAT, d);
  endtask

  task automatic reg_rd(input logic [7:0] r, output logic [7:0] d);
    bwrite(IDX, r);
    bread(DAT, d);
  endtask

  task automatic unlock();
    bwrite(IDX, 8'h87);
    bwrite(IDX, 8'h87);
  endtask

  task automatic t_reset();
    check("R1 cfg_open", cfg_open, 0);
    check("R1 rdata", bus_rdata, 8'h00);
    check("R1 dev_en", wdt_dev_en, 0);
    check("R1 bank", wdt_bank_regs, 0);
  endtask

  task automatic t_closed();
    logic [7:0] v;
    bread(DAT, v); check("R2 closed data read", v, 8'hFF);
    bread(IDX, v); check("R2 closed index read", v, 8'hFF);
    bwrite(DAT, 8'h5A);
    check("R2 closed write no open", cfg_open, 0);
    unlock();
    bread(IDX, v); check("R1 index reset", v, 8'h00);
    reg_rd(8'h07, v); check("R1 ldn reset", v, 8'h00);
    bwrite(IDX, 8'hAA);
  endtask

  task automatic t_unlock();
    logic [7:0] v;
    bwrite(IDX, 8'h87);
    check("R3 one key closed", cfg_open, 0);
    bread(DAT, v);
    check("R3 data read between keys", v, 8'hFF);
    bwrite(IDX, 8'h87);
    check("R3 two keys open", cfg_open, 1);
  endtask

  task automatic t_restart();
    bwrite(IDX, 8'hAA);
    check("R5 close", cfg_open, 0);
    bwrite(IDX, 8'h87);
    bwrite(IDX, 8'h55);
    bwrite(IDX, 8'h87);
    check("R4 restart needs fresh pair", cfg_open, 0);
    bwrite(IDX, 8'h87);
    check("R4 open after fresh pair", cfg_open, 1);
  endtask

  task automatic t_ids();
    logic [7:0] v;
    reg_rd(8'h20, v); check("R7 dev hi", v, 8'hA5);
    reg_rd(8'h21, v); check("R7 dev lo", v, 8'h1C);
    reg_rd(8'h22, v); check("R7 rev", v, 8'h03);
    reg_rd(8'h23, v); check("R7 mfg hi", v, 8'h5A);
    reg_rd(8'h24, v); check("R7 mfg lo", v, 8'hC3);
    reg_wr(8'h20, 8'h00);
    reg_wr(8'h24, 8'h11);
    reg_rd(8'h20, v); check("R7 dev hi write ignored", v, 8'hA5);
    reg_rd(8'h24, v); check("R7 mfg lo write ignored", v, 8'hC3);
  endtask

  task automatic t_global();
    logic [7:0] v;
    reg_wr(8'h25, 8'hA5);
    reg_wr(8'h2F, 8'h3C);
    reg_rd(8'h25, v); check("R8 reg 25", v, 8'hA5);
    reg_rd(8'h2F, v); check("R8 reg 2F", v, 8'h3C);
    bread(IDX, v); check("R6 index readback", v, 8'h2F);
    reg_wr(8'h07, 8'h03);
    reg_rd(8'h07, v); check("R8 ldn rw", v, 8'h03);
  endtask

  task automatic t_bank();
    logic [7:0] v;
    reg_wr(8'h30, 8'h01);
    check("R9 enable blocked other ldn", wdt_dev_en, 0);
    reg_rd(8'h30, v); check("R9 bank read other ldn", v, 8'hFF);
    reg_wr(8'h07, 8'h07);
    reg_wr(8'h30, 8'hFF);
    check("R9 enable set", wdt_dev_en, 1);
    reg_rd(8'h30, v); check("R9 enable readback", v, 8'h01);
    reg_wr(8'hF0, 8'h12);
    reg_wr(8'hFF, 8'h34);
    check("R9 bank F0 out", wdt_bank_regs[7:0], 8'h12);
    check("R9 bank FF out", wdt_bank_regs[127:120], 8'h34);
    reg_rd(8'hF0, v); check("R9 bank F0 read", v, 8'h12);
    reg_wr(8'h07, 8'h02);
    reg_rd(8'hF0, v); check("R9 bank hidden", v, 8'hFF);
    reg_wr(8'hF0, 8'h99);
    check("R9 hidden write ignored", wdt_bank_regs[7:0], 8'h12);
    reg_wr(8'h07, 8'h07);
  endtask

  task automatic t_unimpl();
    logic [7:0] v;
    reg_wr(8'h50, 8'h77);
    reg_rd(8'h50, v); check("R10 unimpl read", v, 8'hFF);
    reg_rd(8'h10, v); check("R10 unimpl low read", v, 8'hFF);
    bread(IDX, v); check("R11 index read", v, 8'h10);
    bread(16'h0080, v); check("R10 off-address read keeps rdata", v, 8'h10);
    bwrite(16'h0080, 8'hAA);
    check("R10 off-address close ignored", cfg_open, 1);
  endtask

  task automatic t_close_keep();
    logic [7:0] v;
    bwrite(IDX, 8'hF0);
    bwrite(IDX, 8'hAA);
    check("R5 closed", cfg_open, 0);
    bwrite(DAT, 8'h00);
    check("R2 closed write bank kept", wdt_bank_regs[7:0], 8'h12);
    unlock();
    bread(IDX, v); check("R5 index survives close", v, 8'hF0);
    bread(DAT, v); check("R5 bank survives close", v, 8'h12);
    reg_rd(8'h25, v); check("R5 global survives close", v, 8'hA5);
    check("R5 enable survives close", wdt_dev_en, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_closed();
    t_unlock();
    t_restart();
    t_ids();
    t_global();
    t_bank();
    t_unimpl();
    t_close_keep();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule